// File: doc/BRIEF.md
# Bridge Window Control Register Bank

This block is the 64-bit register bank of a host-to-PCI bridge. It answers single-beat 64-bit requests that fall inside a 4 KB memory-mapped region. Each register takes one 64-byte slot, so the register index is bits 11:6 of the offset into the region. The bank holds a set of address windows. Each window has three registers: a base, a mask and a translated base. The bank also holds one bridge control register. All of these values leave the block as flat output buses that feed the downstream address translator.

The bank also owns a group of service slots. The error and error-mask slots read as zero. Writes to the error slot are accepted and discarded. A write to the translation-cache flush slot has its data dropped and produces a one-cycle flush pulse. Every other service slot and every index above the map is refused. A refused access returns an error flag with zero data and changes nothing.

The request side is always ready. Each accepted request gets exactly one response on the next cycle, and requests may be issued back to back.

Top module: `bwin_csr_bank`

## Requirements
- R1: The register index is req_addr[11:6], and req_addr[5:0] has no effect. With four windows the index map is as follows. Indices 0–3 are the window bases 0–3, 4–7 the window masks, 8–11 the translated bases, and 12 the control register. The service slots are: 13 latency, 14 reset, 15 error, 16 error mask, 17 error set, 18 single-entry flush, 19 flush-all, 20 monitor control, 21 monitor count. Indices 22–63 are unmapped.
- R2: While reset is held, and after it, every window register is zero and the control register is 64'h0000_0021_0010_0000 (bits 20 and 32 set, value 2 in bits 39:36).
- R3: A write to a window register or the control register stores all 64 data bits. The new value is on the matching output bus in the response cycle, and a later read returns it.
- R4: Reads of index 15, index 16 and index 19 complete without error and return zero.
- R5: A write to index 15 completes without error and leaves every output bus unchanged.
- R6: A write to index 19 completes without error, ignores its data, and raises flush_pulse for exactly the response cycle. Reads and all other accesses leave flush_pulse low.
- R7: Reads and writes of indices 13, 14, 17, 18, 20 and 21, and writes of index 16, complete with rsp_err=1 and rsp_rdata=0, and leave every output bus unchanged.
- R8: Any access to index 22–63 completes with rsp_err=1 and rsp_rdata=0, and changes no state.
- R9: req_ready is always 1. Each cycle with req_valid=1 is followed on the next cycle by exactly one cycle of rsp_valid=1, and rsp_valid is 0 otherwise. Write responses carry rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the 4 KB region |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 64 | Read data, zero on writes and errors |
| win_base | output | 256 | Window base registers, window n at bits 64n+63:64n |
| win_mask | output | 256 | Window mask registers, same packing |
| win_xlat | output | 256 | Translated base registers, same packing |
| ctrl | output | 64 | Bridge control register |
| flush_pulse | output | 1 | One-cycle flush-all strobe |

## Verification
On every cycle, the assertions check the following. Each request has its one-cycle-later response. A refused access returns zero data and leaves every output bus untouched. A flush pulse is always paired with a clean response. A control write lands exactly where it was decoded. The exact index map can only be shown by the bench scenarios. These include the reset values, the read-as-zero slots, the discarded error write, the ignored low address bits and a second reset in mid-run. The bench sends accesses to each slot and compares the outputs against its own model of the register contents.

// File: rtl/bwin_pkg.sv
// Package bwin_pkg
// Holds the access classes shared by the decoder, the storage and the top.
// Assumes nothing beyond a 3-bit encoding of the classes.
package bwin_pkg;

    typedef enum logic [2:0] {
        C_WB    = 3'd0,   // window base
        C_WM    = 3'd1,   // window mask
        C_XB    = 3'd2,   // translated base
        C_CTRL  = 3'd3,   // bridge control
        C_ZERO  = 3'd4,   // reads zero, write discarded
        C_FLUSH = 3'd5,   // flush-all slot
        C_BAD   = 3'd6    // refused access
    } cls_e;

endpackage

// File: rtl/bwin_decode.sv
// Module bwin_decode
// Turns a register index and the access direction into an access class and
// a window slot. Indices after the three window groups are laid out as:
// control, latency, reset, error, error mask, error set, single flush,
// flush-all, monitor control, monitor count. Everything above is unmapped.
// Assumes NWIN >= 2 and that IW bits can hold the last index.
module bwin_decode
    import bwin_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int IW   = 6,
    parameter int SW   = 2
) (
    input  logic [IW-1:0] idx,
    input  logic          wr,
    output cls_e          cls,
    output logic [SW-1:0] slot,
    output logic          err,
    output logic          flush_hit
);

    localparam logic [IW-1:0] I_WM    = IW'(NWIN);
    localparam logic [IW-1:0] I_XB    = IW'(2 * NWIN);
    localparam logic [IW-1:0] I_CTRL  = IW'(3 * NWIN);
    localparam logic [IW-1:0] I_ERR   = IW'(3 * NWIN + 3);
    localparam logic [IW-1:0] I_EMASK = IW'(3 * NWIN + 4);
    localparam logic [IW-1:0] I_FLUSH = IW'(3 * NWIN + 7);

    // Classify the index; anything not listed is refused.
    always_comb begin
        cls  = C_BAD;
        slot = '0;
        if (idx < I_WM) begin
            cls  = C_WB;
            slot = SW'(idx);
        end else if (idx < I_XB) begin
            cls  = C_WM;
            slot = SW'(idx - I_WM);
        end else if (idx < I_CTRL) begin
            cls  = C_XB;
            slot = SW'(idx - I_XB);
        end else if (idx == I_CTRL) begin
            cls = C_CTRL;
        end else if (idx == I_ERR) begin
            cls = C_ZERO;
        end else if (idx == I_EMASK) begin
            cls = wr ? C_BAD : C_ZERO;
        end else if (idx == I_FLUSH) begin
            cls = C_FLUSH;
        end
    end

    // Error and flush strobes derived from the class.
    assign err       = (cls == C_BAD);
    assign flush_hit = wr && (cls == C_FLUSH);

endmodule

// File: rtl/bwin_regs.sv
// Module bwin_regs
// Storage for NWIN windows (base, mask, translated base) and the control
// register, plus the combinational read mux. A write is taken when we is
// high; class and slot pick the target. Assumes the top gates we with the
// request handshake and the decoder error.
module bwin_regs
    import bwin_pkg::*;
#(
    parameter int          NWIN     = 4,
    parameter int          DW       = 64,
    parameter int          SW       = 2,
    parameter logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  cls_e             cls,
    input  logic [SW-1:0]    slot,
    input  logic [DW-1:0]    wdata,
    output logic [NWIN*DW-1:0] wb_o,
    output logic [NWIN*DW-1:0] wm_o,
    output logic [NWIN*DW-1:0] xb_o,
    output logic [DW-1:0]    ctrl_o,
    output logic [DW-1:0]    rd_o
);

    logic [DW-1:0] wb_q [NWIN];
    logic [DW-1:0] wm_q [NWIN];
    logic [DW-1:0] xb_q [NWIN];
    logic [DW-1:0] ctrl_q;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic sel;
        assign sel = we && (slot == SW'(w));

        // Update one window's three registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wb_q[w] <= '0;
                wm_q[w] <= '0;
                xb_q[w] <= '0;
            end else if (sel) begin
                if (cls == C_WB) wb_q[w] <= wdata;
                if (cls == C_WM) wm_q[w] <= wdata;
                if (cls == C_XB) xb_q[w] <= wdata;
            end
        end

        assign wb_o[w*DW +: DW] = wb_q[w];
        assign wm_o[w*DW +: DW] = wm_q[w];
        assign xb_o[w*DW +: DW] = xb_q[w];
    end

    // Control register with its non-zero reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctrl_q <= DW'(CTRL_RST);
        else if (we && cls == C_CTRL)   ctrl_q <= wdata;
    end

    assign ctrl_o = ctrl_q;

    // Read mux; service and refused slots read as zero.
    always_comb begin
        case (cls)
            C_WB:    rd_o = wb_q[slot];
            C_WM:    rd_o = wm_q[slot];
            C_XB:    rd_o = xb_q[slot];
            C_CTRL:  rd_o = ctrl_q;
            default: rd_o = '0;
        endcase
    end

    // R3
    ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && cls == C_CTRL) |=> (ctrl_o == $past(wdata)));

endmodule

// File: rtl/bwin_resp.sv
// Module bwin_resp
// Registers the response one cycle after each accepted request: valid,
// error flag, data (zero on writes and errors) and the flush strobe.
// Assumes the top accepts every valid request.
module bwin_resp #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          wr,
    input  logic          err,
    input  logic          flush_hit,
    input  logic [DW-1:0] rd,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          flush_pulse
);

    // Capture the outcome of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_rdata   <= '0;
            flush_pulse <= 1'b0;
        end else begin
            rsp_valid   <= acc;
            rsp_err     <= acc && err;
            rsp_rdata   <= (acc && !wr && !err) ? rd : '0;
            flush_pulse <= acc && flush_hit;
        end
    end

    // R7
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R6
    flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> (rsp_valid && !rsp_err));

endmodule

// File: rtl/bwin_csr_bank.sv
// Module bwin_csr_bank
// Top of the bridge window register bank. Decodes bits 11:6 of the request
// offset, updates the window and control storage on clean writes, and
// returns one response per request on the next cycle. Assumes 64-bit
// single-beat accesses and a consumer that always takes responses.
module bwin_csr_bank
    import bwin_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int DW   = 64,
    parameter int AW   = 12,
    parameter int SLG  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DW-1:0]      rsp_rdata,
    output logic [NWIN*DW-1:0] win_base,
    output logic [NWIN*DW-1:0] win_mask,
    output logic [NWIN*DW-1:0] win_xlat,
    output logic [DW-1:0]      ctrl,
    output logic               flush_pulse
);

    localparam int IW = AW - SLG;
    localparam int SW = (NWIN > 1) ? $clog2(NWIN) : 1;

    logic [IW-1:0] idx;
    logic          unused_lo;
    cls_e          cls;
    logic [SW-1:0] slot;
    logic          err;
    logic          flush_hit;
    logic          acc;
    logic          we;
    logic [DW-1:0] rd;

    assign idx       = req_addr[AW-1:SLG];
    assign unused_lo = ^req_addr[SLG-1:0];
    assign req_ready = 1'b1;
    assign acc       = req_valid;
    assign we        = acc && req_write && !err;

    bwin_decode #(.NWIN(NWIN), .IW(IW), .SW(SW)) u_dec (
        .idx       (idx),
        .wr        (req_write),
        .cls       (cls),
        .slot      (slot),
        .err       (err),
        .flush_hit (flush_hit)
    );

    bwin_regs #(.NWIN(NWIN), .DW(DW), .SW(SW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .cls    (cls),
        .slot   (slot),
        .wdata  (req_wdata),
        .wb_o   (win_base),
        .wm_o   (win_mask),
        .xb_o   (win_xlat),
        .ctrl_o (ctrl),
        .rd_o   (rd)
    );

    bwin_resp #(.DW(DW)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (acc),
        .wr          (req_write),
        .err         (err),
        .flush_hit   (flush_hit),
        .rd          (rd),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata),
        .flush_pulse (flush_pulse)
    );

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7
    err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($stable(win_base) && $stable(win_mask) &&
                                    $stable(win_xlat) && $stable(ctrl)));

endmodule

// File: tb/bwin_csr_bank_test.sv
module bwin_csr_bank_test;

    localparam int CLK_P = 10;
    localparam int NW = 4;
    localparam logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000;

    typedef struct packed {
        logic        wr;
        logic [5:0]  idx;
        logic [63:0] wd;
        logic        err;
        logic [63:0] rd;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'd0,  64'h1111_0000_0000_0001, 1'b0, 64'h0},                     // R3
        '{1'b0, 6'd0,  64'h0, 1'b0, 64'h1111_0000_0000_0001},                     // R3
        '{1'b1, 6'd5,  64'hAAAA_5555_0000_FFFF, 1'b0, 64'h0},                     // R3
        '{1'b0, 6'd5,  64'h0, 1'b0, 64'hAAAA_5555_0000_FFFF},                     // R3
        '{1'b1, 6'd11, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0},                     // R3
        '{1'b0, 6'd11, 64'h0, 1'b0, 64'h0123_4567_89AB_CDEF},                     // R3
        '{1'b0, 6'd12, 64'h0, 1'b0, 64'h0000_0021_0010_0000},                     // R2
        '{1'b1, 6'd12, 64'hDEAD_BEEF_0000_0003, 1'b0, 64'h0},                     // R3
        '{1'b0, 6'd12, 64'h0, 1'b0, 64'hDEAD_BEEF_0000_0003},                     // R3
        '{1'b0, 6'd15, 64'h0, 1'b0, 64'h0},                                       // R4
        '{1'b0, 6'd16, 64'h0, 1'b0, 64'h0},                                       // R4
        '{1'b0, 6'd19, 64'h0, 1'b0, 64'h0},                                       // R4
        '{1'b1, 6'd15, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'h0},                     // R5
        '{1'b1, 6'd16, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0},                     // R7
        '{1'b0, 6'd13, 64'h0, 1'b1, 64'h0},                                       // R7
        '{1'b1, 6'd14, 64'h5555_5555_5555_5555, 1'b1, 64'h0},                     // R7
        '{1'b0, 6'd17, 64'h0, 1'b1, 64'h0},                                       // R7
        '{1'b1, 6'd18, 64'h1234, 1'b1, 64'h0},                                    // R7
        '{1'b0, 6'd20, 64'h0, 1'b1, 64'h0},                                       // R7
        '{1'b1, 6'd21, 64'h9, 1'b1, 64'h0},                                       // R7
        '{1'b0, 6'd22, 64'h0, 1'b1, 64'h0},                                       // R8
        '{1'b1, 6'd63, 64'hCAFE, 1'b1, 64'h0},                                    // R8
        '{1'b0, 6'd3,  64'h0, 1'b0, 64'h0},                                       // R2
        '{1'b0, 6'd8,  64'h0, 1'b0, 64'h0}                                        // R2
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [63:0]     req_wdata = '0;
    logic            rsp_valid;
    logic            rsp_err;
    logic [63:0]     rsp_rdata;
    logic [NW*64-1:0] win_base;
    logic [NW*64-1:0] win_mask;
    logic [NW*64-1:0] win_xlat;
    logic [63:0]     ctrl;
    logic            flush_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_wb [NW];
    logic [63:0] m_wm [NW];
    logic [63:0] m_xb [NW];
    logic [63:0] m_ctrl;

    always #(CLK_P/2) clk = ~clk;

    bwin_csr_bank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .win_base(win_base), .win_mask(win_mask), .win_xlat(win_xlat),
        .ctrl(ctrl), .flush_pulse(flush_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NW; i++) begin
            m_wb[i] = '0; m_wm[i] = '0; m_xb[i] = '0;
        end
        m_ctrl = CTRL_RST;
    endtask

    task automatic check_state(input string req);
        for (int i = 0; i < NW; i++) begin
            chk(req, win_base[i*64 +: 64], m_wb[i]);
            chk(req, win_mask[i*64 +: 64], m_wm[i]);
            chk(req, win_xlat[i*64 +: 64], m_xb[i]);
        end
        chk(req, ctrl, m_ctrl);
    endtask

    // Drive one request at the falling edge, sample 1 ns after the taking edge.
    task automatic access(input logic wr, input logic [11:0] addr, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic model_write(input logic [5:0] idx, input logic [63:0] wd);
        if (idx < 6'd4)       m_wb[idx[1:0]] = wd;
        else if (idx < 6'd8)  m_wm[idx[1:0]] = wd;
        else if (idx < 6'd12) m_xb[idx[1:0]] = wd;
        else if (idx == 6'd12) m_ctrl = wd;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R2: state while reset is held
        repeat (3) @(posedge clk);
        #1;
        check_state("R2 reset");
        chk("R9 no rsp in reset", {63'b0, rsp_valid}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_state("R2 after reset");
        chk("R9 ready", {63'b0, req_ready}, 64'h1);

        // Table walk, requests issued back to back
        for (int v = 0; v < NV; v++) begin
            access(VEC[v].wr, {VEC[v].idx, 6'b0}, VEC[v].wd);
            if (VEC[v].wr && !VEC[v].err) model_write(VEC[v].idx, VEC[v].wd);
            chk("R9 rsp_valid", {63'b0, rsp_valid}, 64'h1);
            chk("R7 R8 rsp_err", {63'b0, rsp_err}, {63'b0, VEC[v].err});
            chk("R3 R4 rsp_rdata", rsp_rdata, VEC[v].rd);
            chk("R6 no pulse", {63'b0, flush_pulse}, 64'h0);
            check_state("R5 R7 R8 state");
        end
        idle();
        chk("R9 idle no rsp", {63'b0, rsp_valid}, 64'h0);

        // R1: low address bits ignored
        access(1'b1, {6'd3, 6'h38}, 64'h7777_0000_3333_0000);
        model_write(6'd3, 64'h7777_0000_3333_0000);
        check_state("R1 write lowbits");
        access(1'b0, {6'd3, 6'h07}, 64'h0);
        chk("R1 read lowbits", rsp_rdata, 64'h7777_0000_3333_0000);
        access(1'b1, {6'd9, 6'h3F}, 64'h0000_00AB_0000_00CD);
        model_write(6'd9, 64'h0000_00AB_0000_00CD);
        check_state("R1 xlat slot1");
        access(1'b0, {6'd7, 6'h01}, 64'h0);
        chk("R1 mask slot3", rsp_rdata, 64'h0);

        // R6: flush-all write pulses for one cycle
        access(1'b1, {6'd19, 6'h0}, 64'hFFFF_0000_FFFF_0000);
        chk("R6 pulse", {63'b0, flush_pulse}, 64'h1);
        chk("R6 no err", {63'b0, rsp_err}, 64'h0);
        check_state("R6 state");
        idle();
        chk("R6 pulse drop", {63'b0, flush_pulse}, 64'h0);
        chk("R9 single rsp", {63'b0, rsp_valid}, 64'h0);
        access(1'b0, {6'd19, 6'h0}, 64'h0);
        chk("R6 read no pulse", {63'b0, flush_pulse}, 64'h0);
        idle();

        // R2: second reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model_reset();
        check_state("R2 rereset");
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, {6'd12, 6'h0}, 64'h0);
        chk("R2 ctrl read", rsp_rdata, CTRL_RST);
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule